// File: doc/BRIEF.md
# Multi-format Audio Serial Transmitter

This block turns a stream of signed parallel audio samples into a three-wire serial audio link: a bit clock, a word-select (or frame-sync) line and a serial data line. It is always the clock master. Both link clocks come from the system clock through a programmable divider. Five framings can be chosen while the block is disabled: standard I2S, PCM with a one-bit frame sync, PCM with a long frame sync, left-justified and right-justified. They differ in which bit-clock edge the receiver samples on, in the polarity of word select, and in where the word sits inside its slot.

Samples arrive on a valid/ready handshake, one word per slot. If no sample is offered when a slot begins, the slot carries zeros and the block raises an underrun indication. Run-time controls select LSB-first order, invert either link clock, and gate the bit clock so that it toggles only while word bits are on the line. Word width, slot width and, for the PCM framings, the number of words per frame are configuration inputs. All configuration must be held steady while `en` is high.

Top module: `audio_ser_tx`

## Requirements
- R1: While reset is held low, `bclk`, `ws`, `sd`, `s_ready`, `underrun` and `underrun_pulse` are 0. From the second clock with `en` low, `bclk` rests at its idle level: 1 for `fmt` codes 1 and 2 and 0 for the others, XOR `bclk_inv`. `ws` equals `fclk_inv`, `sd` is 0, and `underrun` is 0.
- R2: Each half of a bit period lasts `clk_div`+1 system clocks. With `fmt` 0, 3 or 4, every bit period begins with the uninverted bit clock low, so the receiver samples on the rising edge. With `fmt` 1 or 2, it begins high, so the receiver samples on the falling edge. `sd` changes only at the start of a bit period. The link outputs lag `en` by two clocks.
- R3: `fmt`=0 (I2S): word select is low for the left slot (slot 0) and high for the right slot (slot 1). It changes during the last bit of the preceding slot, so the MSB follows the change by one bit.
- R4: `fmt`=3 (left-justified): word select is high for the left slot and low for the right slot. The first word bit occupies bit 0 of the slot.
- R5: `fmt`=4 (right-justified): word select is as in R4. The last word bit occupies the final bit of the slot, and the leading slot bits are driven low.
- R6: `fmt`=1 (short sync): the sync is high only during the last bit of the last slot of a frame. Each of the `chans` slots carries one word starting at its bit 0.
- R7: `fmt`=2 (long sync): the sync is high from bit 0 of slot 0 through every bit of that slot except its last bit. Words are placed as in R6.
- R8: With `fmt` 0, 3 or 4, a frame always has exactly two slots, whatever the value of `chans`.
- R9: A sample's word is its low `word_len` bits, in two's complement. With `lsb_first`=0, bit `word_len`-1 goes out first. With `lsb_first`=1, bit 0 goes out first.
- R10: `bclk_inv`=1 inverts `bclk` and `fclk_inv`=1 inverts `ws`, in every state.
- R11: With `bclk_gated`=1, `bclk` holds its idle level through any bit period that carries no word bit. In bit periods that carry a word bit it toggles as in R2.
- R12: When `slot_len` exceeds `word_len`, the slot bits that carry no word bit are driven low.
- R13: `s_ready` is high for exactly one clock at the start of each slot, including the first clock in which `en` is high, and never while `en` is low. The sample on `s_data` is taken in that clock if `s_valid` is high.
- R14: If `s_valid` is low in the `s_ready` clock, the slot sends zeros, `underrun_pulse` is high for the next clock, and `underrun` becomes 1 and stays 1 until `en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; configuration changes only while low |
| fmt | input | 3 | Framing code (0 I2S, 1 short sync, 2 long sync, 3 left-justified, 4 right-justified) |
| word_len | input | LEN_W | Word width in bits, 1..DATA_W, at most slot_len |
| slot_len | input | LEN_W | Slot width in bits, 2..SLOT_MAX |
| chans | input | CH_W | Words per frame for codes 1 and 2, 1..MAX_CH |
| lsb_first | input | 1 | Send LSB first |
| bclk_inv | input | 1 | Invert the bit clock |
| fclk_inv | input | 1 | Invert word select / frame sync |
| bclk_gated | input | 1 | Toggle the bit clock only during word bits |
| clk_div | input | DIV_W | Half bit period minus one, in system clocks |
| s_data | input | DATA_W | Sample, word right-aligned |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample taken this clock (slot start) |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |
| underrun_pulse | output | 1 | One-clock underrun indication |
| underrun | output | 1 | Sticky underrun flag, cleared by en low |

## Verification
The hardest situation to reach from the ports is a slot start that finds no sample, in the middle of a running stream. The zero word has to land in the correct slot, and the sticky flag has to survive until the block is disabled. The bench reaches this by supplying a short queue of samples and then letting it run dry, so that underrun strikes mid-frame, a few slots in. Gated clocking is driven with slots wider than the word. The right-justified and long-sync framings are also driven with slots wider than the word, so that padding bits and the handling of the last slot bit are exercised as well.

// File: rtl/audio_ser_pkg.sv
`timescale 1ns/1ps
// Package: shared framing codes and helpers for the audio serial transmitter.
// Assumes codes 5..7 are never applied; they fall back to I2S behaviour.
package audio_ser_pkg;

    typedef enum logic [2:0] {
        FMT_I2S       = 3'd0,
        FMT_PCM_SHORT = 3'd1,
        FMT_PCM_LONG  = 3'd2,
        FMT_LEFT      = 3'd3,
        FMT_RIGHT     = 3'd4
    } fmt_e;

    // True for framings whose receiver samples on the falling bit-clock edge.
    function automatic logic falling_sample(input fmt_e f);
        return (f == FMT_PCM_SHORT) || (f == FMT_PCM_LONG);
    endfunction

    // True for framings whose slot count comes from the channel input.
    function automatic logic uses_chan_count(input fmt_e f);
        return (f == FMT_PCM_SHORT) || (f == FMT_PCM_LONG);
    endfunction

endpackage

// File: rtl/ast_bit_timer.sv
`timescale 1ns/1ps
// Module: bit-period timer.
// Divides the system clock into two half phases per bit period; each half
// lasts clk_div+1 clocks. Held at the start of a bit while run is low.
// Assumes clk_div is steady while run is high.
module ast_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] clk_div,
    output logic             phase,
    output logic             bit_end
);

    logic [DIV_W-1:0] half_cnt_q;
    logic             phase_q;
    logic             half_end;

    assign half_end = (half_cnt_q == clk_div);

    // Count clocks within a half period and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            half_cnt_q <= '0;
            phase_q    <= 1'b0;
        end else if (half_end) begin
            half_cnt_q <= '0;
            phase_q    <= ~phase_q;
        end else begin
            half_cnt_q <= half_cnt_q + DIV_W'(1);
        end
    end

    assign phase   = phase_q;
    assign bit_end = run && phase_q && half_end;

endmodule

// File: rtl/ast_frame_ctr.sv
`timescale 1ns/1ps
// Module: slot and bit position counter.
// Tracks the bit index inside the current slot and the slot index inside
// the frame; both wrap at their configured lengths. Cleared while run is low.
// Assumes slot_len >= 2 and 1 <= nslots, both steady while run is high.
module ast_frame_ctr #(
    parameter int LEN_W = 7,
    parameter int CH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bit_end,
    input  logic [LEN_W-1:0] slot_len,
    input  logic [CH_W-1:0]  nslots,
    output logic [LEN_W-1:0] pos,
    output logic [CH_W-1:0]  slot,
    output logic             slot_last_bit
);

    logic [LEN_W-1:0] pos_q;
    logic [CH_W-1:0]  slot_q;
    logic             frame_last_slot;

    assign slot_last_bit   = (pos_q == slot_len - LEN_W'(1));
    assign frame_last_slot = (slot_q == nslots - CH_W'(1));

    // Advance the bit position at each bit end; roll into the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos_q  <= '0;
            slot_q <= '0;
        end else if (bit_end) begin
            if (slot_last_bit) begin
                pos_q  <= '0;
                slot_q <= frame_last_slot ? '0 : slot_q + CH_W'(1);
            end else begin
                pos_q <= pos_q + LEN_W'(1);
            end
        end
    end

    assign pos  = pos_q;
    assign slot = slot_q;

endmodule

// File: rtl/ast_line_shaper.sv
`timescale 1ns/1ps
// Module: link line shaper.
// Maps the timing state (phase, bit position, slot) and the current word
// onto registered bit clock, word select and serial data for the chosen
// framing, including bit order, clock inversions and clock gating.
// Assumes word_len <= slot_len and word_len <= DATA_W.
module ast_line_shaper
    import audio_ser_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 7,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [2:0]        fmt,
    input  logic              phase,
    input  logic [LEN_W-1:0]  pos,
    input  logic [CH_W-1:0]   slot,
    input  logic [CH_W-1:0]   nslots,
    input  logic              slot_last_bit,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [LEN_W-1:0]  slot_len,
    input  logic [DATA_W-1:0] word,
    input  logic              lsb_first,
    input  logic              bclk_inv,
    input  logic              fclk_inv,
    input  logic              bclk_gated,
    output logic              bclk,
    output logic              ws,
    output logic              sd
);

    fmt_e              fmt_sel;
    logic              rest_level;
    logic [LEN_W-1:0]  lead_pad;
    logic [LEN_W-1:0]  rel_pos;
    logic              in_word;
    logic [LEN_W-1:0]  bit_idx;
    logic [DATA_W-1:0] word_shifted;
    logic              data_bit;
    logic              ws_raw;
    logic              bclk_raw;

    assign fmt_sel    = fmt_e'(fmt);
    assign rest_level = falling_sample(fmt_sel);

    // Locate the current bit relative to the word inside its slot.
    always_comb begin
        lead_pad     = (fmt_sel == FMT_RIGHT) ? (slot_len - word_len) : '0;
        rel_pos      = pos - lead_pad;
        in_word      = (pos >= lead_pad) && (rel_pos < word_len);
        bit_idx      = lsb_first ? rel_pos : (word_len - LEN_W'(1) - rel_pos);
        word_shifted = word >> bit_idx;
        data_bit     = word_shifted[0];
    end

    // Word-select / frame-sync level for each framing.
    always_comb begin
        case (fmt_sel)
            FMT_PCM_SHORT: ws_raw = (slot == nslots - CH_W'(1)) && slot_last_bit;
            FMT_PCM_LONG:  ws_raw = (slot == '0) && !slot_last_bit;
            FMT_LEFT,
            FMT_RIGHT:     ws_raw = (slot == '0);
            default:       ws_raw = (slot == CH_W'(1)) ? !slot_last_bit : slot_last_bit;
        endcase
    end

    // Bit clock: rest level in the first half of a bit, opposite in the second.
    always_comb begin
        if (!run || (bclk_gated && !in_word)) begin
            bclk_raw = rest_level;
        end else begin
            bclk_raw = rest_level ^ phase;
        end
    end

    // Register the three link lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk <= 1'b0;
            ws   <= 1'b0;
            sd   <= 1'b0;
        end else begin
            bclk <= bclk_raw ^ bclk_inv;
            ws   <= (run && ws_raw) ^ fclk_inv;
            sd   <= run && in_word && data_bit;
        end
    end

endmodule

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
// Module: multi-format audio serial transmitter (clock master).
// Accepts one sample per slot through valid/ready and drives bit clock,
// word select and serial data for five framings. A missing sample at a slot
// start sends zeros and raises underrun. Configuration must be held steady
// while en is high; outputs follow en with two clocks of latency.
module audio_ser_tx
    import audio_ser_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SLOT_MAX = 64,
    parameter int MAX_CH   = 8,
    parameter int DIV_W    = 8,
    localparam int LEN_W   = $clog2(SLOT_MAX + 1),
    localparam int CH_W    = $clog2(MAX_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        fmt,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [LEN_W-1:0]  slot_len,
    input  logic [CH_W-1:0]   chans,
    input  logic              lsb_first,
    input  logic              bclk_inv,
    input  logic              fclk_inv,
    input  logic              bclk_gated,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic              bclk,
    output logic              ws,
    output logic              sd,
    output logic              underrun_pulse,
    output logic              underrun
);

    logic              run_q;
    logic [CH_W-1:0]   nslots;
    logic              phase;
    logic              bit_end;
    logic [LEN_W-1:0]  pos;
    logic [CH_W-1:0]   slot;
    logic              slot_last_bit;
    logic              load;
    logic [DATA_W-1:0] word_q;
    logic              ur_pulse_q;
    logic              ur_sticky_q;

    // Register the enable; the serializer runs one clock behind it.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= en;
    end

    // I2S and the justified framings always use two slots per frame.
    assign nslots = uses_chan_count(fmt_e'(fmt)) ? chans : CH_W'(2);

    ast_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .clk_div (clk_div),
        .phase   (phase),
        .bit_end (bit_end)
    );

    ast_frame_ctr #(.LEN_W(LEN_W), .CH_W(CH_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run_q),
        .bit_end       (bit_end),
        .slot_len      (slot_len),
        .nslots        (nslots),
        .pos           (pos),
        .slot          (slot),
        .slot_last_bit (slot_last_bit)
    );

    // A new word is due on the first enabled clock and at every slot start.
    assign load    = en && (!run_q || (bit_end && slot_last_bit));
    assign s_ready = load;

    // Capture the next word or substitute zeros and record an underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q      <= '0;
            ur_pulse_q  <= 1'b0;
            ur_sticky_q <= 1'b0;
        end else begin
            ur_pulse_q <= load && !s_valid;
            if (load) word_q <= s_valid ? s_data : '0;
            if (!en)                    ur_sticky_q <= 1'b0;
            else if (load && !s_valid)  ur_sticky_q <= 1'b1;
        end
    end

    assign underrun_pulse = ur_pulse_q;
    assign underrun       = ur_sticky_q;

    ast_line_shaper #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CH_W(CH_W)) u_shaper (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run_q),
        .fmt           (fmt),
        .phase         (phase),
        .pos           (pos),
        .slot          (slot),
        .nslots        (nslots),
        .slot_last_bit (slot_last_bit),
        .word_len      (word_len),
        .slot_len      (slot_len),
        .word          (word_q),
        .lsb_first     (lsb_first),
        .bclk_inv      (bclk_inv),
        .fclk_inv      (fclk_inv),
        .bclk_gated    (bclk_gated),
        .bclk          (bclk),
        .ws            (ws),
        .sd            (sd)
    );

endmodule

// File: rtl/audio_ser_tx_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for the audio serial transmitter, bound to the top.
// Observes ports only; assumes configuration is steady while en is high.
module audio_ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic bclk_gated,
    input logic s_ready,
    input logic bclk,
    input logic sd,
    input logic underrun_pulse,
    input logic underrun
);

    // R13: a sample is requested at most once in any two consecutive clocks.
    assert_ready_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // R13: no request while disabled.
    assert_no_ready_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !s_ready);

    // R14: the sticky flag holds while enabled.
    assert_sticky_holds_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && en) |=> underrun);

    // R14: every underrun pulse is reflected in the sticky flag.
    assert_pulse_sets_flag_R14: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_pulse |-> underrun);

    // R1: disabling clears the sticky flag.
    assert_idle_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !underrun);

    // R2: in steady running with a free bit clock, data moves only with a clock edge.
    assert_sd_with_bclk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(en, 2) && $past(en, 3) && !bclk_gated && !$stable(sd))
        |-> !$stable(bclk));

endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .bclk_gated     (bclk_gated),
    .s_ready        (s_ready),
    .bclk           (bclk),
    .sd             (sd),
    .underrun_pulse (underrun_pulse),
    .underrun       (underrun)
);

// File: tb/audio_ser_tx_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the transmitter every clock.
module audio_ser_tx_tb_top;

    localparam int DATA_W   = 32;
    localparam int SLOT_MAX = 64;
    localparam int MAX_CH   = 8;
    localparam int DIV_W    = 8;
    localparam int LEN_W    = $clog2(SLOT_MAX + 1);
    localparam int CH_W     = $clog2(MAX_CH + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n, en, s_valid;
    logic [DATA_W-1:0] s_data;
    logic              s_ready, bclk, ws, sd, underrun_pulse, underrun;

    logic [2:0] cfg_fmt;
    int         cfg_wl, cfg_sl, cfg_ch, cfg_div;
    bit         cfg_lsb, cfg_binv, cfg_finv, cfg_gat;

    audio_ser_tx #(.DATA_W(DATA_W), .SLOT_MAX(SLOT_MAX), .MAX_CH(MAX_CH), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .fmt(cfg_fmt),
        .word_len(LEN_W'(cfg_wl)), .slot_len(LEN_W'(cfg_sl)), .chans(CH_W'(cfg_ch)),
        .lsb_first(cfg_lsb), .bclk_inv(cfg_binv), .fclk_inv(cfg_finv), .bclk_gated(cfg_gat),
        .clk_div(DIV_W'(cfg_div)), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .bclk(bclk), .ws(ws), .sd(sd), .underrun_pulse(underrun_pulse), .underrun(underrun)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    bit  checking = 0;
    bit  supply = 1;
    logic [31:0] q[$];

    // reference model state
    bit          m_run, m_outrun, m_ld;
    int          m_t;
    logic [31:0] m_word;
    bit          e_bclk, e_ws, e_sd, e_urp, e_ur;

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int slots_per_frame();
        return (cfg_fmt == 3'd1 || cfg_fmt == 3'd2) ? cfg_ch : 2;  // R8
    endfunction

    function automatic bit rest_lvl();
        return (cfg_fmt == 3'd1 || cfg_fmt == 3'd2);
    endfunction

    function automatic bit slot_begins(input int t);
        int bp = 2 * (cfg_div + 1);
        return (t % bp == 0) && ((t / bp) % cfg_sl == 0);
    endfunction

    // Expected link lines for running time t with word w.
    task automatic expected_line(input int t, input logic [31:0] w,
                                 output bit b, output bit s, output bit d);
        int bp, hp, bitn, fb, bif, sl_i, p, j, nb;
        bit valid, half;
        bp   = 2 * (cfg_div + 1);
        hp   = cfg_div + 1;
        bitn = t / bp;
        half = ((t % bp) >= hp);
        fb   = cfg_sl * slots_per_frame();
        bif  = bitn % fb;
        sl_i = bif / cfg_sl;
        p    = bif % cfg_sl;
        case (cfg_fmt)
            3'd0: begin nb = (bif + 1) % fb; s = ((nb / cfg_sl) == 1); end   // R3
            3'd1: s = (bif == fb - 1);                                       // R6
            3'd2: s = (sl_i == 0) && (p < cfg_sl - 1);                       // R7
            default: s = (sl_i == 0);                                        // R4 R5
        endcase
        j = (cfg_fmt == 3'd4) ? p - (cfg_sl - cfg_wl) : p;                   // R5 R12
        valid = (j >= 0) && (j < cfg_wl);
        d = valid ? (cfg_lsb ? w[j] : w[cfg_wl - 1 - j]) : 1'b0;             // R9
        b = (cfg_gat && !valid) ? rest_lvl() : (rest_lvl() ^ half);          // R2 R11
        b = b ^ cfg_binv;                                                    // R10
        s = s ^ cfg_finv;
    endtask

    // Model update at each active edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_t = 0; m_word = '0; m_outrun = 0;
            e_bclk = 0; e_ws = 0; e_sd = 0; e_urp = 0; e_ur = 0;
        end else begin
            if (m_run) expected_line(m_t, m_word, e_bclk, e_ws, e_sd);
            else begin e_bclk = rest_lvl() ^ cfg_binv; e_ws = cfg_finv; e_sd = 0; end
            m_outrun = m_run;
            m_ld  = en && (!m_run || slot_begins(m_t + 1));
            e_urp = m_ld && !s_valid;
            e_ur  = en ? (e_ur || e_urp) : 1'b0;
            if (m_ld) m_word = s_valid ? q.pop_front() : 32'h0;
            if (en && m_run) m_t++; else m_t = 0;
            m_run = en;
        end
    end

    function automatic string ws_tag();
        case (cfg_fmt)
            3'd0: return "R3 R8 R10";
            3'd1: return "R6 R10";
            3'd2: return "R7 R10";
            3'd3: return "R4 R8 R10";
            default: return "R5 R8 R10";
        endcase
    endfunction

    // Compare every clock, between edges.
    always @(posedge clk) begin
        #1;
        if (checking) begin
            check("R13", "s_ready", s_ready, en && (!m_run || slot_begins(m_t + 1)));
            check(m_outrun ? "R2 R10 R11" : "R1", "bclk", bclk, e_bclk);
            check(m_outrun ? ws_tag() : "R1", "ws", ws, e_ws);
            check(m_outrun ? "R9 R12 R14" : "R1", "sd", sd, e_sd);
            check("R14", "underrun_pulse", underrun_pulse, e_urp);
            check(m_outrun ? "R14" : "R1", "underrun", underrun, e_ur);
        end
    end

    // Sample source: offer queue head, junk data when nothing is offered.
    always @(negedge clk) begin
        s_valid <= supply && (q.size() > 0);
        s_data  <= (supply && q.size() > 0) ? q[0] : 32'hDEAD_BEEF;
    end

    task automatic run_case(input int f, input int wl, input int sl, input int ch,
                            input bit lsb, input bit bi, input bit fi, input bit g,
                            input int dv, input int frames, input int nwords);
        int ns;
        en = 0;
        repeat (3) @(negedge clk);
        q.delete();
        cfg_fmt = 3'(f); cfg_wl = wl; cfg_sl = sl; cfg_ch = ch; cfg_lsb = lsb;
        cfg_binv = bi; cfg_finv = fi; cfg_gat = g; cfg_div = dv;
        repeat (4) @(negedge clk);
        ns = (f == 1 || f == 2) ? ch : 2;
        for (int i = 0; i < nwords; i++) q.push_back($urandom);
        @(negedge clk);
        en = 1;
        repeat (frames * 2 * (dv + 1) * sl * ns) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; en = 0; supply = 1;
        cfg_fmt = 3'd0; cfg_wl = 16; cfg_sl = 16; cfg_ch = 2; cfg_div = 1;
        cfg_lsb = 0; cfg_binv = 0; cfg_finv = 0; cfg_gat = 0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared in reset
        check("R1", "bclk in reset", bclk, 1'b0);
        check("R1", "ws in reset", ws, 1'b0);
        check("R1", "sd in reset", sd, 1'b0);
        check("R1", "s_ready in reset", s_ready, 1'b0);
        check("R1", "underrun in reset", underrun, 1'b0);
        rst_n = 1;
        @(negedge clk);
        checking = 1;
        run_case(0, 16, 16, 2, 0, 0, 0, 0, 1, 4, 10);   // R3 I2S
        run_case(3, 12, 16, 2, 0, 0, 0, 0, 0, 4, 10);   // R4 R12 left-justified
        run_case(4, 10, 16, 2, 0, 0, 1, 0, 2, 3, 8);    // R5 right-justified, R10 frame invert
        run_case(1, 8, 8, 3, 0, 0, 0, 0, 1, 4, 14);     // R6 short sync, three words
        run_case(2, 16, 20, 2, 1, 1, 1, 0, 0, 3, 8);    // R7 R9 long sync, LSB first, both inverted
        run_case(0, 8, 12, 5, 0, 0, 0, 1, 1, 3, 8);     // R8 R11 I2S ignores chans, gated
        run_case(1, 6, 9, 1, 1, 1, 0, 1, 0, 5, 7);      // R6 R11 single word, gated, inverted clock
        run_case(4, 7, 12, 2, 1, 0, 0, 1, 0, 3, 8);     // R5 R11 gated right-justified
        // R14: starve the source mid-stream
        run_case(3, 16, 16, 2, 0, 0, 0, 0, 0, 3, 3);
        check("R14", "underrun sticky while running", underrun, 1'b1);
        check("R14", "zero slot data", sd, 1'b0);
        en = 0;
        repeat (3) @(negedge clk);
        check("R14", "underrun cleared by en low", underrun, 1'b0);
        check("R1", "sd idle", sd, 1'b0);
        check("R1", "ws idle", ws, 1'b0);
        check("R1", "bclk idle", bclk, 1'b0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule